// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt inputs into three banks of 32 and raises one request line towards a processor. Each input has a mask bit. Software never writes the mask directly. It writes a ones-pattern to one of two aliases per bank: one alias enables sources and the other disables them. Software can read the masked pending bits of each bank. It can also read the number of the source that won arbitration. It then writes an acknowledge so that the next winner can be chosen.

The register port is a plain single-cycle 32-bit bus. A write takes effect on the clock edge where `reg_en` and `reg_we` are both high. Read data is combinational from `reg_addr` while `reg_en` is high. The bus has no back-pressure: every access completes in the cycle it is presented. The same port also gives software a revision register, a self-timed soft reset with a completion flag, and a readable autoidle configuration bit.

Register offsets, in bytes: revision 0x00, configuration 0x10, status 0x14, active source 0x40, acknowledge 0x48. The per-bank registers sit at a stride of 0x20 for bank b: mask view at 0x84, enable alias at 0x88, disable alias at 0x8C, and masked pending at 0x98.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After hardware reset, all three mask views read 0xFFFFFFFF, configuration reads 0, `cpu_irq` is 0, status bit 0 reads 0, and status bit 0 reads 1 within 6 cycles.
- R2: Writing the enable alias (0x88 + 0x20*b) clears the mask bits where the written data has a 1 and leaves the other mask bits unchanged.
- R3: Writing the disable alias (0x8C + 0x20*b) sets the mask bits where the written data has a 1 and leaves the other mask bits unchanged.
- R4: The pending register at 0x98 + 0x20*b reads `irq_src[32b+31:32b]` AND NOT mask, in the same cycle.
- R5: When no interrupt awaits acknowledge, the lowest-numbered unmasked active source is latched at the next clock edge. The active-source register (0x40, bits 6:0) then returns its number, and `cpu_irq` goes to 1.
- R6: While `cpu_irq` is 1, the active-source number and `cpu_irq` stay unchanged when inputs change, including when a lower-numbered source arrives or the latched source drops.
- R7: A write to 0x48 with data bit 0 = 1 clears `cpu_irq` at that edge. Arbitration runs again at the following edge. A write to 0x48 with bit 0 = 0 has no effect.
- R8: Writing configuration (0x10) with bit 1 = 1 starts a soft reset. It sets every mask bit, clears autoidle and `cpu_irq`, and clears status bit 0. Status bit 0 returns to 1 four cycles later. No arbitration takes place until then. Bit 1 always reads 0.
- R9: Configuration bit 0 (autoidle) is written by a configuration write that has bit 1 = 0, and reads back.
- R10: The revision register at 0x00 reads 0x21 in bits 7:0 (major 2 in bits 7:4, minor 1 in bits 3:0) and 0 elsewhere.
- R11: The mask view at 0x84 + 0x20*b is read-only: writes to it are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 96 | Level-sensitive interrupt inputs, bit n is source n |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_en is high |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A table of source patterns is applied with every source enabled. The patterns are: single sources at each bank edge (0, 31, 32, 95), and mixes spread across two or three banks. The single-source cases show that the bank concatenation is correct. The mixed cases show that the winner is the lowest index across banks, not within a bank. Directed sequences raise a lower-numbered source while an interrupt is latched. They also drop the latched source and write an acknowledge with bit 0 clear. Together these separate real hold-until-acknowledge behaviour from live re-arbitration. Partial enable and disable patterns on one bank show that the alias writes touch only the bits written as 1.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int OFF_REV    = 'h00;
  localparam int OFF_CFG    = 'h10;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_ACTIVE = 'h40;
  localparam int OFF_ACK    = 'h48;
  localparam int OFF_MASK   = 'h84;
  localparam int OFF_ENA    = 'h88;
  localparam int OFF_DIS    = 'h8C;
  localparam int OFF_PEND   = 'h98;
  localparam int BANK_STEP  = 'h20;
  localparam int ACT_FIELD  = 7;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         ena_we,
  input  logic         dis_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '1;
    else if (srst)   mask_q <= '1;
    else if (ena_we) mask_q <= mask_q & ~wdata;
    else if (dis_we) mask_q <= mask_q | wdata;
  end

  assign mask = mask_q;
  assign pend = src & ~mask_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 96,
  parameter int IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int RST_CYC   = 4,
  parameter logic [3:0] REV_MAJ = 4'h2,
  parameter logic [3:0] REV_MIN = 4'h1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
  input  logic                        reg_en,
  input  logic                        reg_we,
  input  logic [11:0]                 reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        cpu_irq
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int CNT_W   = $clog2(RST_CYC + 1);

  logic              wr, rd;
  logic              cfg_wr, ack_wr, srst;
  logic [BANK_W-1:0] mask_w [NUM_BANKS];
  logic [BANK_W-1:0] pend_w [NUM_BANKS];
  logic [NUM_SRC-1:0] pend_flat;
  logic              any_pend;
  logic [ID_W-1:0]   win_id;
  logic [ID_W-1:0]   act_q;
  logic              wait_q;
  logic              autoidle_q;
  logic [CNT_W-1:0]  rst_cnt;
  logic              rst_done;

  assign wr     = reg_en && reg_we;
  assign rd     = reg_en && !reg_we;
  assign cfg_wr = wr && (int'(reg_addr) == OFF_CFG);
  assign ack_wr = wr && (int'(reg_addr) == OFF_ACK) && reg_wdata[0];
  assign srst   = cfg_wr && reg_wdata[1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic ena_we, dis_we;
    assign ena_we = wr && (int'(reg_addr) == OFF_ENA + b * BANK_STEP);
    assign dis_we = wr && (int'(reg_addr) == OFF_DIS + b * BANK_STEP);
    irq_mask_bank #(.W(BANK_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .ena_we(ena_we),
      .dis_we(dis_we),
      .wdata (reg_wdata[BANK_W-1:0]),
      .src   (irq_src[b*BANK_W +: BANK_W]),
      .mask  (mask_w[b]),
      .pend  (pend_w[b])
    );
    assign pend_flat[b*BANK_W +: BANK_W] = pend_w[b];
  end

  irq_prio_enc #(.N(NUM_SRC), .IW(ID_W)) u_enc (
    .req(pend_flat),
    .any(any_pend),
    .idx(win_id)
  );

  // soft-reset sequencer: done flag rises RST_CYC edges after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rst_cnt <= CNT_W'(RST_CYC);
    else if (srst)           rst_cnt <= CNT_W'(RST_CYC);
    else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
  end
  assign rst_done = (rst_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      autoidle_q <= 1'b0;
    else if (srst)   autoidle_q <= 1'b0;
    else if (cfg_wr) autoidle_q <= reg_wdata[0];
  end

  // latch winner only while nothing awaits acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      act_q  <= '0;
    end else if (srst) begin
      wait_q <= 1'b0;
      act_q  <= '0;
    end else if (ack_wr) begin
      wait_q <= 1'b0;
    end else if (!wait_q && any_pend && rst_done) begin
      wait_q <= 1'b1;
      act_q  <= win_id;
    end
  end

  assign cpu_irq = wait_q;

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      case (int'(reg_addr))
        OFF_REV:    reg_rdata = {24'h0, REV_MAJ, REV_MIN};
        OFF_CFG:    reg_rdata = {31'h0, autoidle_q};
        OFF_STAT:   reg_rdata = {31'h0, rst_done};
        OFF_ACTIVE: reg_rdata = 32'(act_q);
        default: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(reg_addr) == OFF_MASK + b * BANK_STEP) reg_rdata = 32'(mask_w[b]);
            if (int'(reg_addr) == OFF_PEND + b * BANK_STEP) reg_rdata = 32'(pend_w[b]);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int ID_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_en,
  input logic            reg_we,
  input logic [11:0]     reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     reg_rdata,
  input logic            cpu_irq,
  input logic [ID_W-1:0] act_q,
  input logic            any_pend
);
  logic ack_w, srst_w;
  assign ack_w  = reg_en && reg_we && reg_addr == 12'h048 && reg_wdata[0];
  assign srst_w = reg_en && reg_we && reg_addr == 12'h010 && reg_wdata[1];

  AST_RAISE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(any_pend)); // R5
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !ack_w && !srst_w |=> cpu_irq && $stable(act_q)); // R6
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> !cpu_irq); // R7
  AST_SRST_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> !cpu_irq); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !reg_we && reg_addr == 12'h020 |-> reg_rdata == 32'h0); // R11
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_en   (reg_en),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .cpu_irq  (cpu_irq),
  .act_q    (act_q),
  .any_pend (any_pend)
);

// File: tb/sim_irq_bank_ctrl.sv
`timescale 1ns/1ps
module sim_irq_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_src = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  // {expected winner, source pattern}
  localparam logic [102:0] VEC [8] = '{
    {7'd0,  96'h0000_0000_0000_0000_0000_0001},
    {7'd31, 96'h0000_0000_0000_0000_8000_0000},
    {7'd32, 96'h0000_0000_0000_0001_0000_0000},
    {7'd95, 96'h8000_0000_0000_0000_0000_0000},
    {7'd5,  96'h0000_0040_0000_0100_0000_0020},
    {7'd33, 96'h0000_0001_0000_0002_0000_0000},
    {7'd64, 96'h8000_0001_0000_0000_0000_0000},
    {7'd63, 96'h4000_0000_8000_0000_0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int k;
    k = 0;
    s = '0;
    while (k < 6 && s[0] !== 1'b1) begin
      rd(12'h014, s);
      k++;
    end
    check(req, {31'h0, s[0]}, 32'h1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h014, rv); check("R1 status", rv, 32'h0);
    check("R1 irq", {31'h0, cpu_irq}, 32'h0);
    for (int b = 0; b < 3; b++) begin
      rd(12'(12'h084 + b * 12'h020), rv); check("R1 mask", rv, 32'hFFFF_FFFF);
    end
    rd(12'h010, rv); check("R1 cfg", rv, 32'h0);
    wait_done("R1 done");
    // R10 revision
    rd(12'h000, rv); check("R10 rev", rv, 32'h21);
    // R11 unmapped, read-only mask view
    rd(12'h020, rv); check("R11 unmapped", rv, 32'h0);
    wr(12'h084, 32'h0);
    rd(12'h084, rv); check("R11 ro mask", rv, 32'hFFFF_FFFF);

    // main table: all sources enabled (R5, R4, R7)
    for (int b = 0; b < 3; b++) wr(12'(12'h088 + b * 12'h020), 32'hFFFF_FFFF);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      irq_src = VEC[v][95:0];
      @(negedge clk);
      check("R5 irq", {31'h0, cpu_irq}, 32'h1);
      rd(12'h040, rv); check("R5 winner", rv, {25'h0, VEC[v][102:96]});
      for (int b = 0; b < 3; b++) begin
        rd(12'(12'h098 + b * 12'h020), rv); check("R4 pend", rv, VEC[v][b*32 +: 32]);
      end
      irq_src = '0;
      wr(12'h048, 32'h1);
      @(negedge clk);
      check("R7 ack", {31'h0, cpu_irq}, 32'h0);
    end

    // R2/R3 partial alias writes on bank 1
    wr(12'h0AC, 32'hFFFF_FFFF);
    wr(12'h0A8, 32'h0000_00F0);
    rd(12'h0A4, rv); check("R2 enable alias", rv, 32'hFFFF_FF0F);
    wr(12'h0AC, 32'h0000_0030);
    rd(12'h0A4, rv); check("R3 disable alias", rv, 32'hFFFF_FF3F);
    irq_src = {32'h0, 32'hFFFF_FFFF, 32'h0};
    rd(12'h0B8, rv); check("R4 masked pend", rv, 32'h0000_00C0);

    // R6 hold, R7 ack rules: only sources 38,39 enabled in bank 1
    for (int b = 0; b < 3; b += 2) wr(12'(12'h08C + b * 12'h020), 32'hFFFF_FFFF);
    irq_src = '0;
    wr(12'h048, 32'h1);
    irq_src = 96'h0 | (96'h1 << 39);
    @(negedge clk);
    rd(12'h040, rv); check("R5 single", rv, 32'd39);
    irq_src = (96'h1 << 39) | (96'h1 << 38);
    @(negedge clk);
    rd(12'h040, rv); check("R6 hold lower", rv, 32'd39);
    irq_src = 96'h1 << 38;
    @(negedge clk);
    rd(12'h040, rv); check("R6 hold drop", rv, 32'd39);
    check("R6 irq held", {31'h0, cpu_irq}, 32'h1);
    wr(12'h048, 32'h0);
    check("R7 bit0 clear ignored", {31'h0, cpu_irq}, 32'h1);
    wr(12'h048, 32'h1);
    check("R7 ack clears", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    check("R7 rearb irq", {31'h0, cpu_irq}, 32'h1);
    rd(12'h040, rv); check("R7 rearb id", rv, 32'd38);

    // R9 autoidle
    wr(12'h010, 32'h1);
    rd(12'h010, rv); check("R9 autoidle", rv, 32'h1);

    // R8 soft reset with source still active
    wr(12'h010, 32'h3);
    check("R8 irq", {31'h0, cpu_irq}, 32'h0);
    rd(12'h014, rv); check("R8 status low", rv, 32'h0);
    rd(12'h010, rv); check("R8 cfg", rv, 32'h0);
    rd(12'h0A4, rv); check("R8 mask", rv, 32'hFFFF_FFFF);
    wait_done("R8 done");
    wr(12'h0A8, 32'h0000_0040);
    @(negedge clk);
    rd(12'h040, rv); check("R8 arb after done", rv, 32'd38);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule